// File: doc/BRIEF.md
# Parallel Input Capture Controller

This block takes samples from a parallel data port and stores them in a receive FIFO. The port is two 16-bit halves, and it can be read as an 8-bit, 16-bit or 32-bit word. In the 32-bit view the upper half is plain data and has no control lines. A sample can come from one of three sources. The first is a pacer running from the block clock. The second is an external strobe on the request line. The third is a two-wire request/acknowledge handshake with the sending device. Capture can start as soon as the block is enabled, or it can wait for an active edge on a trigger line. The request and trigger inputs each have their own edge polarity, and so does the acknowledge output level. These external control lines pass through two-flop synchronisers before edge detection. The data halves pass through a matching two-stage delay, so each word stays aligned with its strobe.

A small register interface carries the configuration and status. Writes are single-cycle strobes and reads are combinational. A consumer drains the FIFO through a show-ahead pop port.

A sample that arrives while the FIFO is full is dropped, and a sticky overrun flag is set. In handshake mode the acknowledge is held back while the FIFO is full, so the device waits and no data is lost.

Register map (addresses on `reg_addr`):
- 0, control and status: bit0 enable; bits[2:1] source (0 pacer, 1 strobe, 2 handshake, 3 no sampling); bit3 wait-for-trigger; bits[5:4] word width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit); bit6 request polarity; bit7 trigger polarity; bit8 acknowledge polarity; bit9 FIFO clear (write 1, reads 0); bit10 overrun (write 1 to clear); bit11 FIFO full (read-only); bit12 FIFO empty (read-only).
- 1, pacer divisor in bits[15:0].
- 2, FIFO fill level.

Top module: `pcap_top`

## Requirements
- R1: In strobe mode (source 1), each active edge on `req_in` pushes exactly one word taken from the data port. Other edges and steady levels push nothing.
- R2: The word width field maps the data port into the stored word as follows. Code 0 stores `din_lo[7:0]` zero-extended. Code 1 stores `din_lo` zero-extended. Codes 2 and 3 store `{din_hi, din_lo}`.
- R3: In pacer mode (source 0), one word is pushed every D clocks while capture runs, where D is the divisor. A divisor below 2 acts as 2.
- R4: When bit3 is 0, capture runs from the cycle after enable. When bit3 is 1, no word is pushed until an active edge is seen on `trg_in`.
- R5: A polarity bit of 0 selects the rising edge of the line (for `ack_out`, active high). A bit of 1 selects the falling edge (for `ack_out`, active low).
- R6: In handshake mode (source 2), while `req_in` is asserted and the FIFO has space, one word is pushed and `ack_out` asserts. `ack_out` stays asserted until `req_in` deasserts, and then it deasserts.
- R7: In handshake mode, `ack_out` is not asserted while the FIFO is full, and no overrun is raised. It asserts once space appears.
- R8: A sample that arrives while the FIFO is full is discarded and sets the overrun bit. The bit stays set until a control write with bit10 = 1.
- R9: Writing bit9 = 1 empties the FIFO. Bit9 always reads 0.
- R10: After reset the full bit is 0, the empty bit is 1, and the fill level is 0. Full and empty track the fill level, are never both 1, and the level never exceeds the depth.
- R11: Words leave the FIFO in arrival order. `pop_data` shows the oldest word, and `pop` removes it.
- R12: Clearing the enable bit stops capture. Later edges on `req_in` push nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the pacer base |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| din_lo | input | 16 | Lower data half |
| din_hi | input | 16 | Upper data half, used in 32-bit view |
| req_in | input | 1 | External strobe / handshake request |
| trg_in | input | 1 | External start trigger |
| ack_out | output | 1 | Handshake acknowledge |
| pop | input | 1 | Remove the oldest FIFO word |
| pop_data | output | 32 | Oldest FIFO word |
| pop_valid | output | 1 | FIFO holds at least one word |

## Verification
Some properties are checked on every cycle. These are the level bound and the exclusive full/empty flags, the stickiness of overrun, that a clear empties the FIFO on the next cycle, that acknowledge holds while the request is held, that acknowledge never rises out of a full FIFO, and that the level cannot grow while capture is not armed. Other behaviours can only be shown by the bench's scenarios. These are the width packing of real data words, FIFO ordering, the pacer rate and the clamping of small divisors, edge polarity on each line, trigger gating, and the recovery of the handshake once a word is popped.

// File: rtl/pcap_pkg.sv
// Shared types and helpers for the parallel input capture controller.
// Assumes a 32-bit stored word made of two 16-bit port halves.
package pcap_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 16;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_DIV   = 2'd1;
    localparam logic [1:0] ADDR_LEVEL = 2'd2;

    localparam int BIT_CLEAR = 9;
    localparam int BIT_OVR   = 10;
    localparam int BIT_FULL  = 11;
    localparam int BIT_EMPTY = 12;
    localparam int CFG_W     = 9;

    typedef enum logic [1:0] {
        SRC_PACER  = 2'd0,
        SRC_STROBE = 2'd1,
        SRC_HSHK   = 2'd2,
        SRC_NONE   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32B = 2'd3
    } wid_e;

    // Packed so that bit 0 is enable and bit 8 is ack polarity.
    typedef struct packed {
        logic ack_pol;
        logic trg_pol;
        logic req_pol;
        wid_e width;
        logic trig_wait;
        src_e source;
        logic enable;
    } cfg_t;

    // Map the raw two-half port word into the stored word per width mode.
    function automatic logic [WORD_W-1:0] pack_word(wid_e w, logic [WORD_W-1:0] d);
        case (w)
            WID_8:   pack_word = {{(WORD_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
            WID_16:  pack_word = {{(WORD_W-HALF_W){1'b0}}, d[HALF_W-1:0]};
            default: pack_word = d;
        endcase
    endfunction
endpackage

// File: rtl/pcap_sync.sv
// Two-flop synchroniser for N asynchronous control lines, plus a matching
// two-stage delay of the data port, so a word stays aligned with its strobe.
// Assumes the data is held stable around the strobe by the sender.
module pcap_sync #(
    parameter int N_CTRL = 2,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CTRL-1:0] ctrl_in,
    input  logic [DW-1:0]     data_in,
    output logic [N_CTRL-1:0] ctrl_s,
    output logic [DW-1:0]     data_s
);
    logic [DW-1:0] data_d1;

    genvar i;
    generate
        for (i = 0; i < N_CTRL; i++) begin : g_line
            logic meta;
            // Two-flop chain for one control line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta      <= 1'b0;
                    ctrl_s[i] <= 1'b0;
                end else begin
                    meta      <= ctrl_in[i];
                    ctrl_s[i] <= meta;
                end
            end
        end
    endgenerate

    // Data delay matching the control synchroniser depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_d1 <= '0;
            data_s  <= '0;
        end else begin
            data_d1 <= data_in;
            data_s  <= data_d1;
        end
    end
endmodule

// File: rtl/pcap_pacer.sv
// Internal sample pacer: one tick every max(divisor,2) clocks while run is high.
// Assumes the counter restarts from zero whenever run drops.
module pcap_pacer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] divisor,
    output logic          tick
);
    localparam logic [CW-1:0] MIN_DIV = CW'(2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = ((divisor < MIN_DIV) ? MIN_DIV : divisor) - CW'(1);
    assign tick = run && (cnt >= last);

    // Free count within the period, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pcap_fifo.sv
// Show-ahead receive FIFO with behavioural storage and synchronous clear.
// Assumes DEPTH is a power of two; push when full and pop when empty are ignored.
module pcap_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and level bookkeeping; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + (AW+1)'(1);
                2'b01:   level <= level - (AW+1)'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pcap_top.sv
// Parallel input capture controller: selects a sample source, gates the
// start on an optional trigger edge, packs the port word and pushes it into
// the receive FIFO, flagging overrun. Register writes are single strobes.
module pcap_top
    import pcap_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [HALF_W-1:0]  din_lo,
    input  logic [HALF_W-1:0]  din_hi,
    input  logic               req_in,
    input  logic               trg_in,
    output logic               ack_out,
    input  logic               pop,
    output logic [WORD_W-1:0]  pop_data,
    output logic               pop_valid
);
    localparam int IDX_REQ = 0;
    localparam int IDX_TRG = 1;
    localparam int N_CTRL  = 2;

    cfg_t              cfg;
    logic [DIV_W-1:0]  divisor;
    logic              overrun;
    logic              armed;
    logic              hs_ack;

    logic [N_CTRL-1:0] ctrl_s, ctrl_prev;
    logic [WORD_W-1:0] data_s;
    logic              req_lvl, req_edge, trg_edge;
    logic              ctrl_wr, clear_cmd, ovr_clr;
    logic              pacer_tick, sample_evt, push;
    logic              fifo_full, fifo_empty;
    logic [LW-1:0]     fifo_level;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[WORD_W-1:BIT_EMPTY+1], reg_wdata[BIT_EMPTY:BIT_FULL]};

    // Synchronise control lines and delay data to match.
    pcap_sync #(.N_CTRL(N_CTRL), .DW(WORD_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_in ({trg_in, req_in}),
        .data_in ({din_hi, din_lo}),
        .ctrl_s  (ctrl_s),
        .data_s  (data_s)
    );

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_prev <= '0;
        else        ctrl_prev <= ctrl_s;
    end

    assign req_lvl  = ctrl_s[IDX_REQ] ^ cfg.req_pol;
    assign req_edge = cfg.req_pol ? (!ctrl_s[IDX_REQ] && ctrl_prev[IDX_REQ])
                                  : (ctrl_s[IDX_REQ] && !ctrl_prev[IDX_REQ]);
    assign trg_edge = cfg.trg_pol ? (!ctrl_s[IDX_TRG] && ctrl_prev[IDX_TRG])
                                  : (ctrl_s[IDX_TRG] && !ctrl_prev[IDX_TRG]);

    assign ctrl_wr   = reg_we && (reg_addr == ADDR_CTRL);
    assign clear_cmd = ctrl_wr && reg_wdata[BIT_CLEAR];
    assign ovr_clr   = ctrl_wr && reg_wdata[BIT_OVR];

    // Configuration and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            divisor <= DIV_W'(2);
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) cfg     <= cfg_t'(reg_wdata[CFG_W-1:0]);
            if (reg_addr == ADDR_DIV)  divisor <= reg_wdata[DIV_W-1:0];
        end
    end

    // Start gating: arm on enable, or on the trigger edge in wait mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg.enable)                       armed <= 1'b0;
        else if (!armed && (!cfg.trig_wait || trg_edge)) armed <= 1'b1;
    end

    pcap_pacer #(.CW(DIV_W)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (armed && (cfg.source == SRC_PACER)),
        .divisor (divisor),
        .tick    (pacer_tick)
    );

    // Handshake acknowledge: assert with a capture, release after request drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || (cfg.source != SRC_HSHK)) hs_ack <= 1'b0;
        else if (!hs_ack) hs_ack <= req_lvl && !fifo_full;
        else              hs_ack <= req_lvl;
    end

    // Sample event from the selected source.
    always_comb begin
        case (cfg.source)
            SRC_PACER:  sample_evt = pacer_tick;
            SRC_STROBE: sample_evt = armed && req_edge;
            SRC_HSHK:   sample_evt = armed && !hs_ack && req_lvl && !fifo_full;
            default:    sample_evt = 1'b0;
        endcase
    end

    assign push    = sample_evt && !fifo_full;
    assign ack_out = hs_ack ^ cfg.ack_pol;

    // Sticky overrun: set by a dropped sample, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (sample_evt && fifo_full)  overrun <= 1'b1;
        else if (ovr_clr)                  overrun <= 1'b0;
    end

    pcap_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_cmd),
        .push  (push),
        .wdata (pack_word(cfg.width, data_s)),
        .pop   (pop),
        .rdata (pop_data),
        .full  (fifo_full),
        .empty (fifo_empty),
        .level (fifo_level)
    );

    assign pop_valid = !fifo_empty;

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CFG_W-1:0] = cfg;
                reg_rdata[BIT_OVR]   = overrun;
                reg_rdata[BIT_FULL]  = fifo_full;
                reg_rdata[BIT_EMPTY] = fifo_empty;
            end
            ADDR_DIV:   reg_rdata[DIV_W-1:0] = divisor;
            ADDR_LEVEL: reg_rdata[LW-1:0]    = fifo_level;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcap_checker.sv
// Cycle-level properties of the capture controller, bound into pcap_top.
module pcap_checker #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          overrun,
    input logic          ovr_clr,
    input logic          clear_cmd,
    input logic          ctrl_wr,
    input logic          hs_mode,
    input logic          ack_act,
    input logic          req_lvl,
    input logic          armed
);
    AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH); // R10
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> empty); // R9
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode && ack_act && req_lvl && !ctrl_wr |=> ack_act); // R6
    AST_NO_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_act) |-> !$past(full)); // R7
    AST_UNARMED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> level <= $past(level)); // R4
endmodule

bind pcap_top pcap_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .overrun   (overrun),
    .ovr_clr   (ovr_clr),
    .clear_cmd (clear_cmd),
    .ctrl_wr   (ctrl_wr),
    .hs_mode   (cfg.source == pcap_pkg::SRC_HSHK),
    .ack_act   (hs_ack),
    .req_lvl   (req_lvl),
    .armed     (armed)
);

// File: tb/pcap_top_test.sv
`timescale 1ns/1ps
module pcap_top_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] din_lo = '0, din_hi = '0;
    logic        req_in = 1'b0, trg_in = 1'b0;
    logic        ack_out;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        pop_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    pcap_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din_lo(din_lo),
        .din_hi(din_hi), .req_in(req_in), .trg_in(trg_in), .ack_out(ack_out),
        .pop(pop), .pop_data(pop_data), .pop_valid(pop_valid)
    );

    // Vectors: {width[65:64], hi[63:48], lo[47:32], expected[31:0]}
    localparam logic [65:0] VECS [6] = '{
        {2'd0, 16'h1234, 16'hABCD, 32'h0000_00CD},
        {2'd1, 16'h1234, 16'hABCD, 32'h0000_ABCD},
        {2'd2, 16'h1234, 16'hABCD, 32'h1234_ABCD},
        {2'd3, 16'hFFFF, 16'h0001, 32'hFFFF_0001},
        {2'd0, 16'hFFFF, 16'h00FF, 32'h0000_00FF},
        {2'd1, 16'h5A5A, 16'h8001, 32'h0000_8001}
    };

    function automatic logic [31:0] mkctrl(logic en, logic [1:0] src, logic tw,
                                           logic [1:0] wid, logic rp, logic tp, logic ap);
        return {23'd0, ap, tp, rp, wid, tw, src, en};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req_in = ~req_in;
        cycles(3);
        req_in = ~req_in;
        cycles(4);
    endtask

    task automatic wait_ack(input logic lvl);
        for (int k = 0; k < 20 && ack_out !== lvl; k++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R10: reset state
        rd(2'd0, rv);
        check(rv[12] === 1'b1 && rv[11] === 1'b0 && rv[10] === 1'b0, "R10 reset flags", rv, 32'h1000);
        rd(2'd2, rv);
        check(rv === 32'd0, "R10 reset level", rv, 0);
        check(ack_out === 1'b0, "R6 reset ack", {31'd0, ack_out}, 0);

        // R1/R2: vector walk in strobe mode
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, mkctrl(1, 2'd1, 0, VECS[i][65:64], 0, 0, 0));
            din_hi = VECS[i][63:48];
            din_lo = VECS[i][47:32];
            pulse_req();
            rd(2'd2, rv);
            check(rv === 32'd1, "R1 one push per edge", rv, 1);
            check(pop_data === VECS[i][31:0], "R2 width packing", pop_data, VECS[i][31:0]);
            do_pop();
            wr(2'd0, 32'd0);
        end

        // R11: order
        wr(2'd0, mkctrl(1, 2'd1, 0, 2'd1, 0, 0, 0));
        for (int i = 1; i <= 3; i++) begin
            din_lo = 16'(i * 16'h111);
            pulse_req();
        end
        for (int i = 1; i <= 3; i++) begin
            check(pop_data === 32'(i * 16'h111), "R11 fifo order", pop_data, 32'(i * 16'h111));
            do_pop();
        end
        check(pop_valid === 1'b0, "R11 drained", {31'd0, pop_valid}, 0);

        // R12: disable stops capture
        wr(2'd0, 32'd0);
        pulse_req();
        rd(2'd2, rv);
        check(rv === 32'd0, "R12 disabled no capture", rv, 0);

        // R5: falling-edge request
        req_in = 1'b1;
        cycles(4);
        wr(2'd0, mkctrl(1, 2'd1, 0, 2'd1, 1, 0, 0));
        cycles(4);
        @(negedge clk); req_in = 1'b0;
        cycles(5);
        rd(2'd2, rv);
        check(rv === 32'd1, "R5 falling req samples", rv, 1);
        @(negedge clk); req_in = 1'b1;
        cycles(5);
        rd(2'd2, rv);
        check(rv === 32'd1, "R5 rising req ignored", rv, 1);
        wr(2'd0, 32'd0);
        req_in = 1'b0;
        wr(2'd0, 32'h200);

        // R4/R5: trigger wait on falling trigger edge
        trg_in = 1'b1;
        cycles(4);
        wr(2'd0, mkctrl(1, 2'd1, 1, 2'd1, 0, 1, 0));
        pulse_req();
        rd(2'd2, rv);
        check(rv === 32'd0, "R4 no sample before trigger", rv, 0);
        @(negedge clk); trg_in = 1'b0;
        cycles(5);
        pulse_req();
        rd(2'd2, rv);
        check(rv === 32'd1, "R4 sample after trigger", rv, 1);
        wr(2'd0, 32'h200);
        trg_in = 1'b0;

        // R3: pacer divisor 5 for 50 cycles
        wr(2'd1, 32'd5);
        wr(2'd0, mkctrl(1, 2'd0, 0, 2'd1, 0, 0, 0));
        cycles(50);
        wr(2'd0, 32'd0);
        rd(2'd2, rv);
        check(rv >= 32'd9 && rv <= 32'd10, "R3 pacer rate div5", rv, 10);
        wr(2'd0, 32'h200);

        // R3: divisor 1 acts as 2
        wr(2'd1, 32'd1);
        wr(2'd0, mkctrl(1, 2'd0, 0, 2'd1, 0, 0, 0));
        cycles(24);
        wr(2'd0, 32'd0);
        rd(2'd2, rv);
        check(rv >= 32'd11 && rv <= 32'd13, "R3 pacer clamp", rv, 12);
        rd(2'd0, rv);
        check(rv[10] === 1'b0, "R3 no overrun at clamp", rv, 0);
        wr(2'd0, 32'h200);

        // R8: overrun
        wr(2'd0, mkctrl(1, 2'd1, 0, 2'd1, 0, 0, 0));
        for (int i = 0; i < DEPTH; i++) begin
            din_lo = 16'(i);
            pulse_req();
        end
        rd(2'd0, rv);
        check(rv[11] === 1'b1 && rv[10] === 1'b0, "R10 full flag", rv, 32'h801);
        din_lo = 16'hEEEE;
        pulse_req();
        rd(2'd0, rv);
        check(rv[10] === 1'b1, "R8 overrun set", rv, 32'h400);
        rd(2'd2, rv);
        check(rv === 32'(DEPTH), "R8 sample dropped", rv, 32'(DEPTH));
        check(pop_data === 32'd0, "R8 head unchanged", pop_data, 0);
        wr(2'd0, mkctrl(1, 2'd1, 0, 2'd1, 0, 0, 0));
        rd(2'd0, rv);
        check(rv[10] === 1'b1, "R8 overrun sticky", rv, 32'h400);
        wr(2'd0, mkctrl(1, 2'd1, 0, 2'd1, 0, 0, 0) | 32'h400);
        rd(2'd0, rv);
        check(rv[10] === 1'b0, "R8 overrun w1c", rv, 0);

        // R9: clear
        wr(2'd0, 32'h200);
        rd(2'd0, rv);
        check(rv[12] === 1'b1 && rv[9] === 1'b0, "R9 clear empties reads 0", rv, 32'h1000);

        // R6/R7/R5: handshake with active-low ack
        wr(2'd0, mkctrl(1, 2'd2, 0, 2'd1, 0, 0, 1));
        cycles(2);
        check(ack_out === 1'b1, "R5 ack idle high when active low", {31'd0, ack_out}, 1);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); req_in = 1'b1;
            wait_ack(1'b0);
            @(negedge clk); req_in = 1'b0;
            wait_ack(1'b1);
        end
        rd(2'd2, rv);
        check(rv === 32'(DEPTH), "R6 handshake fills", rv, 32'(DEPTH));
        @(negedge clk); req_in = 1'b1;
        cycles(8);
        check(ack_out === 1'b1, "R7 ack withheld when full", {31'd0, ack_out}, 1);
        rd(2'd0, rv);
        check(rv[10] === 1'b0, "R7 no overrun", rv, 0);
        do_pop();
        cycles(3);
        check(ack_out === 1'b0, "R7 ack after space", {31'd0, ack_out}, 0);
        rd(2'd2, rv);
        check(rv === 32'(DEPTH), "R6 one word per ack", rv, 32'(DEPTH));
        cycles(4);
        check(ack_out === 1'b0, "R6 ack held with req", {31'd0, ack_out}, 0);
        @(negedge clk); req_in = 1'b0;
        cycles(4);
        check(ack_out === 1'b1, "R6 ack release", {31'd0, ack_out}, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule